// File: doc/BRIEF.md
# Reconfigurable Convolutional Symbol Generator

This block feeds the branch-metric stage of a Viterbi decoder whose code is picked at run time. A start pulse captures a constraint length, a rate selector and up to four generator polynomials. The block then steps through every encoder state of that code. For each state it offers both input-bit hypotheses, in turn, together with the coded symbol the encoder would emit on that branch. The downstream unit can then compare received soft symbols against the table without any knowledge of how the trellis is wired.

Entries leave through a valid/ready handshake. The table index advances by one on each accepted transfer. One cycle after the final entry is accepted, a single-cycle completion pulse marks the end of the sweep.

Top module: `conv_sym_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `sym_valid` and `done` are low.
- R2: A `start` pulse seen while no sweep runs captures `cfg_k`, `cfg_rate` and `cfg_poly`. In the next cycle `sym_valid` is high, with state 0 and input bit 0.
- R3: Entries follow the index `{sym_state, sym_bit}` counting up from 0 to 2^K-1, so each state shows input bit 0 and then input bit 1. The index advances only on a cycle where `sym_valid` and `sym_ready` are both high.
- R4: Symbol bit j is the XOR parity of polynomial j ANDed with a K-bit register. Polynomial j occupies `cfg_poly[9j+8:9j]`. In the register, bit K-1 holds the input bit and bits K-2..0 hold the state index.
- R5: `cfg_rate` 0 selects rate 1/2, which drives symbol bits 0..1. A value of 1 selects rate 1/3, which drives bits 0..2. A value of 2 or 3 selects rate 1/4, which drives bits 0..3. Symbol bits above the rate are zero.
- R6: Polynomial bits at positions K and above have no effect on the symbols.
- R7: K is taken from `cfg_k` over the range 3..9. A value below 3 acts as 3 and a value above 9 acts as 9.
- R8: Changes to the configuration inputs, and `start` pulses, have no effect while a sweep runs.
- R9: While `sym_valid` is high and `sym_ready` is low, the state, input bit and symbol outputs hold steady and `sym_valid` stays high.
- R10: One cycle after the last entry is accepted, `done` is high for exactly one cycle and `sym_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sweep and captures the configuration |
| cfg_k | input | 4 | Constraint length |
| cfg_rate | input | 2 | Rate selector |
| cfg_poly | input | 36 | Four 9-bit generator polynomials, polynomial j in bits 9j+8:9j |
| sym_valid | output | 1 | Table entry offered |
| sym_ready | input | 1 | Consumer takes the entry |
| sym_state | output | 8 | Encoder state of the entry |
| sym_bit | output | 1 | Hypothesised input bit |
| sym_code | output | 4 | Expected coded symbol bits |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Every constraint length from 3 to 9 is swept with every rate selector. Each sweep uses fresh random polynomials whose upper bits are usually set, which separates correct tap masking from leakage of taps above K. Sweeps with all-zero and all-one polynomials pin down the parity itself. Sweeps with `cfg_k` set to 2 and 15 exercise the clamping. Ready is held high in some sweeps and toggled pseudo-randomly in others, which exposes index skips or drift during stalls. Some sweeps also pulse `start` with a scrambled configuration partway through, to show that the captured code is kept.

// File: rtl/conv_sym_gen.sv
module conv_sym_gen #(
  parameter int KMAX = 9,
  parameter int KMIN = 3,
  parameter int NOUT = 4,
  localparam int SW = KMAX - 1,
  localparam int KW = $clog2(KMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [KW-1:0]        cfg_k,
  input  logic [1:0]           cfg_rate,
  input  logic [NOUT*KMAX-1:0] cfg_poly,
  output logic                 sym_valid,
  input  logic                 sym_ready,
  output logic [SW-1:0]        sym_state,
  output logic                 sym_bit,
  output logic [NOUT-1:0]      sym_code,
  output logic                 done
);

  logic [KW-1:0]        k_q;
  logic [1:0]           rate_q;
  logic [NOUT*KMAX-1:0] poly_q;
  logic [KMAX-1:0]      idx;
  logic                 busy_q, done_q;

  logic [KW-1:0] k_in;
  assign k_in = (cfg_k < KW'(KMIN)) ? KW'(KMIN) :
                (cfg_k > KW'(KMAX)) ? KW'(KMAX) : cfg_k;

  logic [KMAX-1:0] mask, regv, last_idx;
  assign mask     = {KMAX{1'b1}} >> (KMAX - int'(k_q));
  assign last_idx = mask;
  assign regv     = ({{(KMAX-1){1'b0}}, idx[0]} << (k_q - 1'b1)) | {1'b0, idx[KMAX-1:1]};

  for (genvar j = 0; j < NOUT; j++) begin : g_sym
    assign sym_code[j] = (int'(rate_q) + 2 > j) && (^(poly_q[j*KMAX +: KMAX] & mask & regv));
  end

  logic accept, last;
  assign accept = busy_q & sym_ready;
  assign last   = (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q    <= KW'(KMIN);
      rate_q <= '0;
      poly_q <= '0;
      idx    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        k_q    <= k_in;
        rate_q <= cfg_rate;
        poly_q <= cfg_poly;
        idx    <= '0;
        busy_q <= 1'b1;
      end else if (accept) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign sym_valid = busy_q;
  assign sym_state = idx[KMAX-1:1];
  assign sym_bit   = idx[0];
  assign done      = done_q;

endmodule

// File: rtl/conv_sym_gen_chk.sv
module conv_sym_gen_chk #(
  parameter int KMAX = 9,
  parameter int NOUT = 4,
  localparam int SW = KMAX - 1,
  localparam int KW = $clog2(KMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sym_valid,
  input logic            sym_ready,
  input logic [SW-1:0]   sym_state,
  input logic            sym_bit,
  input logic [NOUT-1:0] sym_code,
  input logic            done,
  input logic [KW-1:0]   k_q,
  input logic [1:0]      rate_q
);

  AST_FIRST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid) |-> (sym_state == '0 && !sym_bit)); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (!sym_valid || {sym_state, sym_bit} == $past({sym_state, sym_bit}) + 1'b1)); // R3

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> ((int'(sym_state) >> (int'(k_q) - 1)) == 0)); // R3

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> ((int'(sym_code) >> (int'(rate_q) + 2)) == 0)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_state) && $stable(sym_bit) && $stable(sym_code))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sym_valid); // R10

endmodule

bind conv_sym_gen conv_sym_gen_chk #(.KMAX(KMAX), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .sym_state(sym_state), .sym_bit(sym_bit), .sym_code(sym_code), .done(done),
  .k_q(k_q), .rate_q(rate_q)
);

// File: tb/sim_conv_sym_gen.sv
`timescale 1ns/1ps
module sim_conv_sym_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_k = 4'd3;
  logic [1:0]  cfg_rate = 2'd0;
  logic [35:0] cfg_poly = '0;
  logic        sym_ready = 1'b0;
  logic        sym_valid, sym_bit, done;
  logic [7:0]  sym_state;
  logic [3:0]  sym_code;

  int n_chk = 0, n_bad = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  conv_sym_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_k(cfg_k), .cfg_rate(cfg_rate),
    .cfg_poly(cfg_poly), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_state(sym_state), .sym_bit(sym_bit), .sym_code(sym_code), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_code(input int kk, input int rate, input logic [35:0] p, input int i);
    logic [8:0] r;
    logic [8:0] m;
    logic [3:0] c;
    int nb;
    m  = 9'((1 << kk) - 1);
    r  = 9'(((i & 1) << (kk - 1)) | (i >> 1));
    nb = (rate == 0) ? 2 : (rate == 1) ? 3 : 4;
    c  = '0;
    for (int j = 0; j < 4; j++)
      if (j < nb) c[j] = ^(p[j*9 +: 9] & m & r);
    return c;
  endfunction

  task automatic sweep(input logic [3:0] k, input logic [1:0] rate, input logic [35:0] p,
                       input bit rnd, input bit poke);
    int kk, total, e;
    logic [12:0] prev;
    bit stalled;
    kk    = (k < 3) ? 3 : (k > 9) ? 9 : int'(k);
    total = 1 << kk;
    e     = 0;
    stalled = 1'b0;
    prev  = '0;
    @(negedge clk);
    cfg_k = k; cfg_rate = rate; cfg_poly = p; start = 1'b1; sym_ready = 1'b0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cfg_k = ~k; cfg_rate = ~rate; cfg_poly = ~p;   // R8: inputs scrambled mid-sweep
      if (e == total) begin
        check(done && !sym_valid, "R10 done pulse", {14'd0, done, sym_valid}, 16'h2);
        @(negedge clk);
        check(!done, "R10 done single", {15'd0, done}, 16'h0);
        break;
      end
      if (stalled)
        check({sym_state, sym_bit, sym_code} == prev, "R9 hold on stall",
              {3'd0, sym_state, sym_bit, sym_code}, {3'd0, prev});
      check(sym_valid && {sym_state, sym_bit} == 9'(e) && sym_code == ref_code(kk, int'(rate), p, e),
            (e == 0) ? "R2 first entry" : "R3 R4 R5 R6 R7 R8 entry",
            {2'd0, sym_valid, sym_state, sym_bit, sym_code},
            {2'd0, 1'b1, 9'(e), ref_code(kk, int'(rate), p, e)});
      prev = {sym_state, sym_bit, sym_code};
      if (poke && e == 3) start = 1'b1;   // R8: restart ignored while busy
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sym_ready = rnd ? lf[0] : 1'b1;
      stalled = !sym_ready;
      if (sym_ready) e++;
    end
    sym_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] p;
    repeat (3) @(negedge clk);
    check(!sym_valid && !done, "R1 reset idle", {14'd0, sym_valid, done}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sym_valid && !done, "R1 after reset", {14'd0, sym_valid, done}, 16'h0);

    sweep(4'd3, 2'd0, 36'h0_0000_0000, 1'b0, 1'b0);
    sweep(4'd5, 2'd2, 36'hF_FFFF_FFFF, 1'b1, 1'b0);
    sweep(4'd2, 2'd1, 36'h0_F0E_1C2D, 1'b1, 1'b1);   // R7 low clamp
    sweep(4'd15, 2'd3, 36'h5_A5A5_A5A5, 1'b0, 1'b1); // R7 high clamp
    for (int k = 3; k <= 9; k++)
      for (int r = 0; r < 4; r++) begin
        p[31:0]  = $urandom();
        p[35:32] = 4'($urandom());
        sweep(4'(k), 2'(r), p, r[0], r[1]);
      end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule